// File: doc/BRIEF.md
# Selectable-Tap Noise Generator Channel

This block is a one-bit pseudo-random noise voice for a sound generator. A 15-bit linear feedback shift register is stepped by a divider. The divider counts processor clock cycles. Its period comes from a fixed table of sixteen even values, selected by a 4-bit index. A mode bit picks the second feedback tap. One setting gives a very long sequence and the other gives a short, buzzy, almost tonal one.

The voice emits a 4-bit level. That level is either the volume supplied from an external envelope unit or zero. It is zero whenever the low bit of the shift register is set, or whenever the external length unit reports that it has run out. Software configures the voice through one 8-bit write port qualified by a strobe. The envelope, length unit and mixer sit outside this block.

Top module: `noise_channel`

## Requirements
- R1: A write (`wr_en` high at a rising edge) stores `wr_data[7]` as the mode bit and `wr_data[3:0]` as the period index. Bits 6 to 4 of the written byte have no effect on the output.
- R2: On each shift step the feedback bit is computed first. It is register bit 0 XOR bit 1 in mode 0, and bit 0 XOR bit 6 in mode 1. The register then moves right by one place, bit 14 takes the feedback, and the register is never all-zero.
- R3: Reset gives register value 1, mode 0 and index 0. The first shift happens at the fourth rising edge after reset is released, so `level` is 0 before that edge and equals `volume` after it.
- R4: The number of clock cycles between shift steps for index 0 to 15 is 4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068.
- R5: The divider counts down by one each cycle and reloads when it reaches zero, producing one shift step. A newly written index is used only at the next reload.
- R6: `level` is 0 whenever register bit 0 is 1.
- R7: `level` is 0 whenever `len_active` is low.
- R8: In mode 0 the output bit sequence repeats every 32767 shift steps.
- R9: In mode 1 the output bit sequence repeats every 93 shift steps; the true period is either 93 or 31.
- R10: Otherwise `level` equals `volume`, combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the mode/period byte |
| wr_data | input | 8 | Mode in bit 7, period index in bits 3:0 |
| volume | input | 4 | Volume from the envelope unit |
| len_active | input | 1 | High while the length unit is non-zero |
| level | output | 4 | Gated noise level to the mixer |

## Verification
A write lands at the rising edge where the strobe is seen. A shift step lands at the edge where the divider sits at zero, so a period of P cycles puts P edges between steps. The register change shows on `level` right after that edge. A change on `volume` or `len_active` shows on `level` within the same cycle.

The bench drives its inputs on falling edges. It advances its own count-and-shift model at each rising edge, using the inputs that were present before that edge. It then compares `level` on the following falling edge, which puts every result in the cycle it is due. Sequence lengths are checked from bits recorded at the port just after each step.

// File: rtl/noise_pkg.sv
package noise_pkg;

    localparam int unsigned NZ_LFSR_W = 15;
    localparam int unsigned NZ_IDX_W  = 4;
    localparam int unsigned NZ_CNT_W  = 12;
    localparam int unsigned NZ_VOL_W  = 4;

    typedef struct packed {
        logic                short_mode;
        logic [NZ_IDX_W-1:0] rate_sel;
    } nz_cfg_t;

    // Cycles between shift steps, per rate selector (all even: two cycles per sound-unit tick)
    function automatic logic [NZ_CNT_W-1:0] nz_period(input logic [NZ_IDX_W-1:0] sel);
        logic [NZ_CNT_W-1:0] p;
        case (sel)
            4'd0:    p = 12'd4;
            4'd1:    p = 12'd8;
            4'd2:    p = 12'd16;
            4'd3:    p = 12'd32;
            4'd4:    p = 12'd64;
            4'd5:    p = 12'd96;
            4'd6:    p = 12'd128;
            4'd7:    p = 12'd160;
            4'd8:    p = 12'd202;
            4'd9:    p = 12'd254;
            4'd10:   p = 12'd380;
            4'd11:   p = 12'd508;
            4'd12:   p = 12'd762;
            4'd13:   p = 12'd1016;
            4'd14:   p = 12'd2034;
            default: p = 12'd4068;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/noise_divider.sv
module noise_divider
    import noise_pkg::*;
#(
    parameter int unsigned CNT_W = NZ_CNT_W,
    parameter int unsigned IDX_W = NZ_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rate_sel,
    output logic             step,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0] RESET_CNT = CNT_W'(nz_period('0)) - ONE;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        step = (st_q.cnt == '0);
        if (step) begin
            st_d.cnt = CNT_W'(nz_period(rate_sel)) - ONE;
        end else begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= RESET_CNT;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr
    import noise_pkg::*;
#(
    parameter int unsigned WIDTH     = NZ_LFSR_W,
    parameter int unsigned TAP_LONG  = 1,
    parameter int unsigned TAP_SHORT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             short_mode,
    output logic [WIDTH-1:0] state
);

    localparam logic [WIDTH-1:0] SEED = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] sr;
    } sr_state_t;

    sr_state_t st_d, st_q;
    logic      feedback;

    always_comb begin
        st_d     = st_q;
        feedback = st_q.sr[0] ^ (short_mode ? st_q.sr[TAP_SHORT] : st_q.sr[TAP_LONG]);
        if (step) begin
            st_d.sr = {feedback, st_q.sr[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q.sr;

endmodule

// File: rtl/noise_channel.sv
module noise_channel
    import noise_pkg::*;
#(
    parameter int unsigned LFSR_W = NZ_LFSR_W,
    parameter int unsigned IDX_W  = NZ_IDX_W,
    parameter int unsigned CNT_W  = NZ_CNT_W,
    parameter int unsigned VOL_W  = NZ_VOL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [VOL_W-1:0] volume,
    input  logic             len_active,
    output logic [VOL_W-1:0] level
);

    localparam int unsigned MODE_BIT = 7;

    nz_cfg_t          cfg_d, cfg_q;
    logic             step;
    logic [CNT_W-1:0] count;
    logic [LFSR_W-1:0] sr;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^wr_data[MODE_BIT-1:IDX_W];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.short_mode = wr_data[MODE_BIT];
            cfg_d.rate_sel   = wr_data[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    noise_divider #(
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (cfg_q.rate_sel),
        .step     (step),
        .count    (count)
    );

    noise_lfsr #(
        .WIDTH     (LFSR_W),
        .TAP_LONG  (1),
        .TAP_SHORT (6)
    ) u_lfsr (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .short_mode (cfg_q.short_mode),
        .state      (sr)
    );

    always_comb begin
        if (sr[0] || !len_active) begin
            level = '0;
        end else begin
            level = volume;
        end
    end

endmodule

// File: rtl/noise_channel_checker.sv
module noise_channel_checker #(
    parameter int unsigned LFSR_W = 15,
    parameter int unsigned CNT_W  = 12,
    parameter int unsigned VOL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step,
    input logic [CNT_W-1:0]  count,
    input logic [LFSR_W-1:0] sr,
    input logic [VOL_W-1:0]  volume,
    input logic              len_active,
    input logic [VOL_W-1:0]  level
);

    assert_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sr != '0);

    assert_shift_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> sr[LFSR_W-2:0] == $past(sr[LFSR_W-1:1]));

    assert_hold_between_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(sr));

    assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> count == $past(count) - CNT_W'(1));

    assert_reload_odd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> count[0]);

    assert_gate_bit0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sr[0] |-> level == '0);

    assert_gate_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !len_active |-> level == '0);

    assert_pass_volume_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr[0] && len_active) |-> level == volume);

endmodule

bind noise_channel noise_channel_checker #(
    .LFSR_W (LFSR_W),
    .CNT_W  (CNT_W),
    .VOL_W  (VOL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .count      (count),
    .sr         (sr),
    .volume     (volume),
    .len_active (len_active),
    .level      (level)
);

// File: tb/noise_channel_test.sv
module noise_channel_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] volume = 4'hF;
    logic       len_active = 1'b1;
    logic [3:0] level;

    int n_checks = 0;
    int n_fail   = 0;

    int tbl[16] = '{4, 8, 16, 32, 64, 96, 128, 160, 202, 254, 380, 508, 762, 1016, 2034, 4068};

    // behavioural model state
    int m_cnt;
    int m_sr;
    int m_mode;
    int m_sel;
    bit m_stepped;

    bit early_bits[40];
    bit late_bits[40];
    bit short_bits[186];

    noise_channel uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .volume     (volume),
        .len_active (len_active),
        .level      (level)
    );

    always #10 clk = ~clk;

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cnt = tbl[0] - 1;
        m_sr = 1;
        m_mode = 0;
        m_sel = 0;
        m_stepped = 0;
    endtask

    function automatic int expected_level();
        if ((m_sr % 2) == 1 || !len_active) return 0;
        return int'(volume);
    endfunction

    // drive at falling edge, model at rising edge, compare at next falling edge
    task automatic cyc(input bit we, input logic [7:0] d, input string tag);
        int fb;
        int other;
        wr_en = we;
        wr_data = d;
        @(posedge clk);
        m_stepped = (m_cnt == 0);
        if (m_stepped) begin
            other = m_mode ? ((m_sr / 64) % 2) : ((m_sr / 2) % 2);
            fb = (m_sr % 2) ^ other;
            m_sr = (m_sr / 2) + fb * 16384;
            m_cnt = tbl[m_sel] - 1;
        end else begin
            m_cnt = m_cnt - 1;
        end
        if (we) begin
            m_mode = d[7];
            m_sel = int'(d[3:0]);
        end
        @(negedge clk);
        wr_en = 1'b0;
        check(int'(level) == expected_level(), tag, int'(level), expected_level());
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int shifts;
        int k;
        int cnt_since;
        model_reset();
        repeat (3) @(negedge clk);
        // R3: level during reset (register holds 1)
        check(level == 4'd0, "R3", int'(level), 0);
        rst_n = 1'b1;

        // R3: first shift at the fourth rising edge
        cyc(0, 8'h00, "R3");
        cyc(0, 8'h00, "R3");
        cyc(0, 8'h00, "R3");
        check(level == 4'd0, "R3", int'(level), 0);
        cyc(0, 8'h00, "R3");
        check(level == 4'hF, "R3", int'(level), 15);
        early_bits[0] = (level == 4'd0);
        shifts = 1;

        // R8: long mode over one full period plus a window
        while (shifts < 32807) begin
            cyc(0, 8'h00, "R8");
            if (m_stepped) begin
                if (shifts < 40) early_bits[shifts] = (level == 4'd0);
                if (shifts >= 32767) late_bits[shifts - 32767] = (level == 4'd0);
                shifts++;
            end
        end
        for (int i = 0; i < 40; i++) begin
            check(early_bits[i] == late_bits[i], "R8", int'(late_bits[i]), int'(early_bits[i]));
        end

        // R7 and R10: vary volume and length status cycle by cycle
        for (int i = 0; i < 64; i++) begin
            volume = 4'(i);
            len_active = (i % 3) != 0;
            cyc(0, 8'h00, (i % 3) != 0 ? "R10" : "R7");
        end
        volume = 4'hF;
        len_active = 1'b1;

        // R9: short mode, index 0
        cyc(1, 8'h80, "R1");
        k = 0;
        while (k < 186) begin
            cyc(0, 8'h00, "R9");
            if (m_stepped) begin
                short_bits[k] = (level == 4'd0);
                k++;
            end
        end
        for (int i = 0; i < 93; i++) begin
            check(short_bits[i] == short_bits[i + 93], "R9", int'(short_bits[i + 93]), int'(short_bits[i]));
        end

        // R1: bits 6:4 ignored, index 1 long mode
        cyc(1, 8'h71, "R1");
        repeat (40) cyc(0, 8'h00, "R1");

        // R4: several period indices, step spacing measured against the table
        foreach (tbl[j]) begin
            if (j == 2 || j == 5 || j == 8 || j == 9 || j == 12) begin
                cyc(1, 8'(j), "R4");
                while (!m_stepped) cyc(0, 8'h00, "R4");
                cnt_since = 0;
                do begin
                    cyc(0, 8'h00, "R4");
                    cnt_since++;
                end while (!m_stepped);
                check(cnt_since == tbl[j], "R4", cnt_since, tbl[j]);
                repeat (3) cyc(0, 8'h00, "R4");
            end
        end

        // R5: index change mid-count waits for the reload
        cyc(1, 8'h8F, "R5");
        while (!m_stepped) cyc(0, 8'h00, "R5");
        repeat (10) cyc(0, 8'h00, "R5");
        cyc(1, 8'h80, "R5");
        cnt_since = 11;
        do begin
            cyc(0, 8'h00, "R5");
            cnt_since++;
        end while (!m_stepped);
        check(cnt_since == 4068, "R5", cnt_since, 4068);
        cnt_since = 0;
        do begin
            cyc(0, 8'h00, "R5");
            cnt_since++;
        end while (!m_stepped);
        check(cnt_since == 4, "R5", cnt_since, 4);

        // R6: whenever the model register low bit is set, level is zero
        repeat (60) begin
            cyc(0, 8'h00, "R6");
            if ((m_sr % 2) == 1) check(level == 4'd0, "R6", int'(level), 0);
        end

        report();
        $finish;
    end

endmodule